// File: doc/BRIEF.md
# Synchronized PWM Register Update Controller

This block holds three independent PWM generators and the logic that decides when their new settings take effect. Each generator has a 16-bit down-counter, a load value that sets the period, and two compare values. Compare A sets the output duty and compare B is stored alongside it. Software writes new values into shadow copies through a simple register write port. The running generator keeps using its active copies until software asks for a commit.

To ask for a commit, software sets one request bit per generator in a control word. The request waits until that generator's counter reaches zero. At that point the shadow values move into the active set in a single clock edge, and the request bit clears itself. Software cannot withdraw a request once it is armed. Because of this, a generator's period and duty only ever change at a period boundary.

Top module: `pwm_commit_top`

## Requirements
- R1: After reset, the control word, every shadow register, every active register and every counter read 0, and all PWM outputs are low.
- R2: The control word is at byte address 0x00. Bit g (g = 0, 1, 2) is the commit request of generator g. Writing 1 to bit g arms that request, and the bit reads 1 while the request is pending.
- R3: Writing 0 to a request bit has no effect. An armed request stays set until its commit happens.
- R4: Bits 31 to 3 of the control word read as 0, and writes to them are ignored.
- R5: Generator g's registers are at byte address 0x20*(g+1) + 4*f. Field f=0 is the load shadow, f=1 the compare A shadow and f=2 the compare B shadow, all writable from bits 15:0. Fields f=4, 5 and 6 read the active load, compare A and compare B. Field f=7 reads the counter. A shadow write leaves the active values unchanged until a commit.
- R6: A commit happens on the clock edge that ends a cycle in which the request is set and the counter reads 0. On the next cycle the active values equal the shadows, the request bit reads 0, and the counter holds the new load value.
- R7: A commit on one generator leaves the active values and the request bit of every other generator unchanged.
- R8: When the shadows are rewritten while a request is armed, the values present in the zero cycle are the ones committed.
- R9: Each counter steps down by 1 per cycle from the active load value to 0, then reloads. A generator's PWM output is high exactly while its count is above its active compare A value, so it is high for load minus compare A cycles of each load+1 cycle period when compare A is below load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 8 | Write byte address |
| wrData | input | 32 | Write data |
| rdAddr | input | 8 | Read byte address |
| rdData | output | 32 | Read data, combinational from rdAddr |
| pwmOut | output | 3 | PWM output of each generator |

## Verification
The assertions assume the write port carries clean, single-cycle writes. They assume reset holds long enough to zero all state. They also assume software never writes a 1 to a request bit on the edge where that same request commits; a write there re-arms the request and would break the clear check. The stimulus keeps to this by arming a generator only when its request reads 0, or when its counter reads well above zero. Read addresses only change between clock edges.

// File: rtl/pwm_commit_pkg.sv
package pwm_commit_pkg;
  localparam int NGEN   = 3;
  localparam int VAL_W  = 16;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;
  localparam int FIELD_LSB = 2;
  localparam int REGION_LSB = 5;

  typedef struct packed {
    logic [NGEN-1:0] commit;
    logic [NGEN-1:0] wrLoad;
    logic [NGEN-1:0] wrCmpA;
    logic [NGEN-1:0] wrCmpB;
  } strobe_t;

  typedef struct packed {
    logic [VAL_W-1:0] shLoad;
    logic [VAL_W-1:0] shCmpA;
    logic [VAL_W-1:0] shCmpB;
    logic [VAL_W-1:0] actLoad;
    logic [VAL_W-1:0] actCmpA;
    logic [VAL_W-1:0] actCmpB;
    logic [VAL_W-1:0] count;
  } genView_t;
endpackage

// File: rtl/pwm_commit_gen.sv
module pwm_commit_gen
  import pwm_commit_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrLoad,
  input  logic             wrCmpA,
  input  logic             wrCmpB,
  input  logic             commit,
  input  logic [VAL_W-1:0] wrValue,
  output genView_t         view,
  output logic             zero,
  output logic             pwm
);
  logic [VAL_W-1:0] shLoad, shCmpA, shCmpB;
  logic [VAL_W-1:0] actLoad, actCmpA, actCmpB;
  logic [VAL_W-1:0] count;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shLoad <= '0;
      shCmpA <= '0;
      shCmpB <= '0;
    end else begin
      if (wrLoad) shLoad <= wrValue;
      if (wrCmpA) shCmpA <= wrValue;
      if (wrCmpB) shCmpB <= wrValue;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      actLoad <= '0;
      actCmpA <= '0;
      actCmpB <= '0;
    end else if (commit) begin
      actLoad <= shLoad;
      actCmpA <= shCmpA;
      actCmpB <= shCmpB;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
    end else if (count == '0) begin
      count <= commit ? shLoad : actLoad;
    end else begin
      count <= count - 1'b1;
    end
  end

  assign zero = (count == '0);
  assign pwm  = (count > actCmpA);

  always_comb begin
    view.shLoad  = shLoad;
    view.shCmpA  = shCmpA;
    view.shCmpB  = shCmpB;
    view.actLoad = actLoad;
    view.actCmpA = actCmpA;
    view.actCmpB = actCmpB;
    view.count   = count;
  end
endmodule

// File: rtl/pwm_commit_dp.sv
module pwm_commit_dp
  import pwm_commit_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               strobe,
  input  logic [VAL_W-1:0]      wrValue,
  output genView_t [NGEN-1:0]   views,
  output logic [NGEN-1:0]       zeros,
  output logic [NGEN-1:0]       pwmOut
);
  for (genvar g = 0; g < NGEN; g++) begin : gGen
    pwm_commit_gen u_gen (
      .clk    (clk),
      .rstN   (rstN),
      .wrLoad (strobe.wrLoad[g]),
      .wrCmpA (strobe.wrCmpA[g]),
      .wrCmpB (strobe.wrCmpB[g]),
      .commit (strobe.commit[g]),
      .wrValue(wrValue),
      .view   (views[g]),
      .zero   (zeros[g]),
      .pwm    (pwmOut[g])
    );
  end
endmodule

// File: rtl/pwm_commit_ctrl.sv
module pwm_commit_ctrl
  import pwm_commit_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [ADDR_W-1:0]     wrAddr,
  input  logic [DATA_W-1:0]     wrData,
  input  logic [ADDR_W-1:0]     rdAddr,
  input  logic [NGEN-1:0]       zeros,
  input  genView_t [NGEN-1:0]   views,
  output strobe_t               strobe,
  output logic [NGEN-1:0]       reqBits,
  output logic [DATA_W-1:0]     rdData
);
  localparam int REGION_W = ADDR_W - REGION_LSB;
  localparam int FIELD_W  = REGION_LSB - FIELD_LSB;

  logic [REGION_W-1:0] wrRegion, rdRegion;
  logic [FIELD_W-1:0]  wrField, rdField;
  logic                ctrlHit;
  logic [NGEN-1:0]     armSet, req, commit;

  assign wrRegion = wrAddr[ADDR_W-1:REGION_LSB];
  assign wrField  = wrAddr[REGION_LSB-1:FIELD_LSB];
  assign rdRegion = rdAddr[ADDR_W-1:REGION_LSB];
  assign rdField  = rdAddr[REGION_LSB-1:FIELD_LSB];

  assign ctrlHit = wrEn && (wrAddr == '0);
  assign armSet  = ctrlHit ? wrData[NGEN-1:0] : '0;
  assign commit  = req & zeros;

  always_ff @(posedge clk) begin
    if (!rstN) req <= '0;
    else       req <= (req & ~commit) | armSet;
  end

  always_comb begin
    strobe = '0;
    strobe.commit = commit;
    for (int g = 0; g < NGEN; g++) begin
      if (wrEn && (int'(wrRegion) == g + 1) && wrAddr[FIELD_LSB-1:0] == '0) begin
        strobe.wrLoad[g] = (wrField == FIELD_W'(0));
        strobe.wrCmpA[g] = (wrField == FIELD_W'(1));
        strobe.wrCmpB[g] = (wrField == FIELD_W'(2));
      end
    end
  end

  always_comb begin
    rdData = '0;
    if (rdAddr == '0) rdData[NGEN-1:0] = req;
    for (int g = 0; g < NGEN; g++) begin
      if (int'(rdRegion) == g + 1) begin
        case (rdField)
          FIELD_W'(0): rdData[VAL_W-1:0] = views[g].shLoad;
          FIELD_W'(1): rdData[VAL_W-1:0] = views[g].shCmpA;
          FIELD_W'(2): rdData[VAL_W-1:0] = views[g].shCmpB;
          FIELD_W'(4): rdData[VAL_W-1:0] = views[g].actLoad;
          FIELD_W'(5): rdData[VAL_W-1:0] = views[g].actCmpA;
          FIELD_W'(6): rdData[VAL_W-1:0] = views[g].actCmpB;
          FIELD_W'(7): rdData[VAL_W-1:0] = views[g].count;
          default:     rdData = '0;
        endcase
      end
    end
  end

  assign reqBits = req;
endmodule

// File: rtl/pwm_commit_top.sv
module pwm_commit_top
  import pwm_commit_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic [NGEN-1:0]   pwmOut
);
  strobe_t               strobe;
  genView_t [NGEN-1:0]   genViews;
  logic [NGEN-1:0]       zeroBits;
  logic [NGEN-1:0]       reqBits;

  pwm_commit_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .rdAddr (rdAddr),
    .zeros  (zeroBits),
    .views  (genViews),
    .strobe (strobe),
    .reqBits(reqBits),
    .rdData (rdData)
  );

  pwm_commit_dp u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .wrValue(wrData[VAL_W-1:0]),
    .views  (genViews),
    .zeros  (zeroBits),
    .pwmOut (pwmOut)
  );
endmodule

// File: rtl/pwm_commit_chk.sv
module pwm_commit_chk
  import pwm_commit_pkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic [NGEN-1:0]     req,
  input logic [NGEN-1:0]     zero,
  input genView_t [NGEN-1:0] view,
  input logic                wrEn,
  input logic [ADDR_W-1:0]   wrAddr,
  input logic [DATA_W-1:0]   wrData,
  input logic [ADDR_W-1:0]   rdAddr,
  input logic [DATA_W-1:0]   rdData
);
  logic [NGEN-1:0] arm;
  assign arm = (wrEn && wrAddr == '0) ? wrData[NGEN-1:0] : '0;

  a_r4_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddr == '0) |-> (rdData[DATA_W-1:NGEN] == '0));

  for (genvar g = 0; g < NGEN; g++) begin : gChk
    a_r3_no_cancel: assert property (@(posedge clk) disable iff (!rstN)
      (req[g] && !zero[g]) |=> req[g]);

    a_r6_self_clear: assert property (@(posedge clk) disable iff (!rstN)
      (req[g] && zero[g] && !arm[g]) |=> !req[g]);

    a_r6_copy: assert property (@(posedge clk) disable iff (!rstN)
      (req[g] && zero[g]) |=> (view[g].actLoad == $past(view[g].shLoad)) &&
                              (view[g].actCmpA == $past(view[g].shCmpA)) &&
                              (view[g].actCmpB == $past(view[g].shCmpB)));

    a_r5_active_hold: assert property (@(posedge clk) disable iff (!rstN)
      !(req[g] && zero[g]) |=> $stable(view[g].actLoad) &&
                               $stable(view[g].actCmpA) && $stable(view[g].actCmpB));

    a_r9_count_down: assert property (@(posedge clk) disable iff (!rstN)
      (view[g].count != '0) |=> (view[g].count == $past(view[g].count) - 16'd1));

    a_r9_reload: assert property (@(posedge clk) disable iff (!rstN)
      (view[g].count == '0) |=> (view[g].count == view[g].actLoad));
  end
endmodule

bind pwm_commit_top pwm_commit_chk chk (
  .clk   (clk),
  .rstN  (rstN),
  .req   (reqBits),
  .zero  (zeroBits),
  .view  (genViews),
  .wrEn  (wrEn),
  .wrAddr(wrAddr),
  .wrData(wrData),
  .rdAddr(rdAddr),
  .rdData(rdData)
);

// File: tb/pwm_commit_top_test.sv
`timescale 1ns/100ps
module pwm_commit_top_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [7:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [7:0]  rdAddr = '0;
  logic [31:0] rdData;
  logic [2:0]  pwmOut;

  int nChecks = 0;
  int nFail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pwm_commit_top uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .pwmOut(pwmOut)
  );

  // gen(2) load(16) cmpA(16) cmpB(16)
  localparam logic [49:0] VEC [4] = '{
    {2'd0, 16'd20, 16'd5,  16'd12},
    {2'd1, 16'd37, 16'd30, 16'd3},
    {2'd2, 16'd9,  16'd0,  16'd9},
    {2'd0, 16'd50, 16'd49, 16'd1}
  };

  function automatic logic [7:0] addrOf(input int g, input int f);
    return 8'((g + 1) * 32 + f * 4);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    rdAddr = a;
    #0.1;
    d = rdData;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrAddr = '0; wrData = '0;
  endtask

  task automatic waitClear(input int g, input string tag);
    logic [31:0] d;
    bit ok = 0;
    for (int i = 0; i < 3000; i++) begin
      rd(8'h00, d);
      if (!d[g]) begin ok = 1; break; end
      @(negedge clk);
    end
    check(tag, 32'(ok), 32'd1);
  endtask

  task automatic waitCountAbove(input int g, input int lim);
    logic [31:0] d;
    for (int i = 0; i < 3000; i++) begin
      rd(addrOf(g, 7), d);
      if (d > 32'(lim)) break;
      @(negedge clk);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [31:0] d, c0, c1;
    logic [15:0] actL [3];
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    rd(8'h00, d); check("R1 ctrl", d, 32'd0);
    for (int g = 0; g < 3; g++) begin
      for (int f = 0; f < 8; f++) begin
        if (f != 3) begin rd(addrOf(g, f), d); check("R1 regs", d, 32'd0); end
      end
      actL[g] = '0;
    end
    check("R1 pwm", 32'(pwmOut), 32'd0);

    // R4: reserved bits ignored
    wr(8'h00, 32'hFFFF_FFF8);
    rd(8'h00, d); check("R4 reserved", d, 32'd0);

    // R2/R5/R6/R9: vector table
    for (int v = 0; v < 4; v++) begin
      int g, ld, ca, cb, hi;
      g  = int'(VEC[v][49:48]);
      ld = int'(VEC[v][47:32]);
      ca = int'(VEC[v][31:16]);
      cb = int'(VEC[v][15:0]);
      wr(addrOf(g, 0), 32'(ld));
      wr(addrOf(g, 1), 32'(ca));
      wr(addrOf(g, 2), 32'(cb));
      rd(addrOf(g, 4), d); check("R5 active held", d, 32'(actL[g]));
      rd(addrOf(g, 0), d); check("R5 shadow", d, 32'(ld));
      wr(8'h00, 32'(1 << g));
      waitClear(g, "R2 commit completes");
      rd(addrOf(g, 4), d); check("R6 load", d, 32'(ld));
      rd(addrOf(g, 5), d); check("R6 cmpA", d, 32'(ca));
      rd(addrOf(g, 6), d); check("R6 cmpB", d, 32'(cb));
      actL[g] = 16'(ld);
      hi = 0;
      for (int k = 0; k <= ld; k++) begin
        @(negedge clk);
        if (pwmOut[g]) hi++;
      end
      check("R9 duty", 32'(hi), 32'(ld - ca));
    end

    // R2: request reads set; R3: writing 0 does not cancel
    waitCountAbove(1, 25);
    wr(addrOf(1, 0), 32'd200);
    wr(8'h00, 32'h2);
    rd(8'h00, d); check("R2 armed bit1", d, 32'h2);
    wr(8'h00, 32'h0);
    rd(8'h00, d); check("R3 no cancel", d, 32'h2);
    waitClear(1, "R3 clears after commit");
    rd(addrOf(1, 4), d); check("R3 committed", d, 32'd200);
    actL[1] = 16'd200;

    // R9: counter steps down by one
    waitCountAbove(1, 5);
    rd(addrOf(1, 7), c0);
    @(negedge clk);
    rd(addrOf(1, 7), c1);
    check("R9 decrement", c1, c0 - 32'd1);

    // R6: exact cycle of commit
    wr(addrOf(2, 0), 32'd15);
    wr(8'h00, 32'h4);
    for (int i = 0; i < 100; i++) begin
      rd(addrOf(2, 7), d);
      if (d == 0) break;
      @(negedge clk);
    end
    rd(8'h00, d);      check("R6 set in zero cycle", d & 32'h4, 32'h4);
    rd(addrOf(2, 4), d); check("R6 old load in zero cycle", d, 32'd9);
    @(negedge clk);
    rd(8'h00, d);      check("R6 clear next cycle", d & 32'h4, 32'h0);
    rd(addrOf(2, 4), d); check("R6 new load next cycle", d, 32'd15);
    rd(addrOf(2, 7), d); check("R6 reload new value", d, 32'd15);

    // R8: latest shadow wins
    waitCountAbove(0, 25);
    wr(addrOf(0, 0), 32'd60);
    wr(8'h00, 32'h1);
    wr(addrOf(0, 0), 32'd77);
    waitClear(0, "R8 clears");
    rd(addrOf(0, 4), d); check("R8 latest value", d, 32'd77);

    // R7: independence
    wr(addrOf(1, 0), 32'd99);
    wr(addrOf(0, 0), 32'd44);
    wr(8'h00, 32'h1);
    waitClear(0, "R7 gen0 clears");
    rd(addrOf(0, 4), d); check("R7 gen0 committed", d, 32'd44);
    rd(addrOf(1, 4), d); check("R7 gen1 untouched", d, 32'(actL[1]));
    rd(8'h00, d);        check("R7 no stray request", d, 32'd0);

    finishRun();
  end
endmodule